// File: doc/BRIEF.md
# Transmit Frame Padder and FCS Appender

This block sits in a transmit path, after the DMA engine has turned descriptors into a byte stream and before the MAC. Frame bytes arrive one per beat on a valid/ready handshake, with a start-of-frame marker and an end-of-frame marker. The first beat of each frame also carries two control flags: one that turns off the frame check sequence (FCS) and one that turns off padding. The block forwards data bytes unchanged. It pads short frames with zero bytes up to the Ethernet minimum. It appends a CRC-32 when the flags and the frame length call for one.

Data beats go straight through with no latency. While pad or FCS bytes are being sent, the block generates them itself and holds its input off. Back-pressure from the MAC side stalls the block at any point and loses nothing.

Top module: `tx_pad_crc`

## Requirements
- R1: A data beat accepted on the input appears on the output in the same cycle with the same byte, and bytes keep their order.
- R2: When the padding-off flag of a frame is clear and the frame has fewer than 60 payload bytes, zero bytes (0x00) follow the payload until 60 bytes have been sent.
- R3: A frame that has been padded always gets a 4-byte FCS, even when its FCS-off flag is set.
- R4: A frame that needs no padding (60 or more bytes, or padding-off set) gets an FCS when its FCS-off flag is clear, and none when the flag is set. Frames of 60 or more bytes are never lengthened except by the FCS.
- R5: The FCS is CRC-32 with reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and final inversion. It is computed over the payload and the pad bytes and sent least significant byte first.
- R6: The FCS-off and padding-off flags are taken only from the beat whose start marker is set. Their values on later beats of the same frame have no effect.
- R7: Input ready is low during every pad or FCS byte, so no input beat is taken then.
- R8: While output valid is high and output ready is low, the output byte and end marker hold their values into the next cycle.
- R9: The output end marker is set on the last FCS byte when an FCS is added, otherwise on the last payload byte, and on no other beat.
- R10: During reset and right after it, output valid is low while no input is offered, and input ready follows output ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8 | Input frame byte |
| in_first | input | 1 | Beat is the first byte of a frame |
| in_last | input | 1 | Beat is the last payload byte of a frame |
| in_fcs_off | input | 1 | Do not append FCS (read with the first beat only) |
| in_pad_off | input | 1 | Do not pad short frames (read with the first beat only) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final byte of the outgoing frame |

## Verification
Payload bytes appear on the output in the same cycle they are accepted, because the data path has no register. The first pad byte, or the first FCS byte, is offered in the cycle after the last payload byte is taken. The FCS follows in the cycle after the sixtieth byte leaves. The bench changes inputs on the falling edge and samples both handshakes one nanosecond later, so every byte is recorded in the cycle in which it transfers. Each frame is then compared against a byte list built by the bench from the requirements. Stalled runs stretch this timing only by the number of cycles in which output ready is low.

// File: rtl/tx_pad_crc_pkg.sv
// Shared types and the CRC-32 byte step for the transmit padder.
// Assumes the reflected IEEE CRC-32 with the state kept uninverted.
package tx_pad_crc_pkg;

    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_PAD  = 2'd1,
        PH_FCS  = 2'd2
    } phase_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Folds one byte into a running reflected CRC-32 state, LSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] state,
                                               input logic [7:0]  din);
        logic [31:0] s;
        s = state ^ {24'd0, din};
        for (int k = 0; k < 8; k++) begin
            s = s[0] ? ((s >> 1) ^ CRC_POLY_REFL) : (s >> 1);
        end
        return s;
    endfunction

endpackage

// File: rtl/txpc_crc_reg.sv
// Running CRC-32 register. It reseeds to all ones when restart is set
// with a byte, and folds in one byte per advance. Its output is the
// final (inverted) FCS value. Assumes restart comes only with advance.
module txpc_crc_reg
    import tx_pad_crc_pkg::*;
#(
    parameter int CRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] fcs
);
    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] seed;

    // Pick the seed: all ones at frame start, else the running state.
    always_comb seed = restart ? {CRC_W{1'b1}} : state_q;

    // Fold each accepted byte into the state.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= {CRC_W{1'b1}};
        else if (advance) state_q <= crc32_step(seed, din);
    end

    // Output the final inversion of the state.
    always_comb fcs = ~state_q;
endmodule

// File: rtl/txpc_len_ctr.sv
// Saturating byte counter for the padder. cnt_next is the count that
// includes the byte advancing this cycle: 1 on restart, otherwise one
// more than before, capped at LIMIT.
module txpc_len_ctr #(
    parameter int LIMIT = 60,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [CW-1:0] cnt_next
);
    logic [CW-1:0] cnt_q;

    // Work out the count that includes the current byte.
    always_comb begin
        if (restart)                 cnt_next = CW'(1);
        else if (cnt_q == CW'(LIMIT)) cnt_next = cnt_q;
        else                         cnt_next = cnt_q + CW'(1);
    end

    // Store the count when a byte advances.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (advance) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/tx_pad_crc.sv
// Transmit padder and FCS appender. Payload beats pass through with no
// latency. Short frames are padded with zeros up to MIN_PAYLOAD bytes,
// and a 4-byte CRC-32 goes out LSB first when required. Assumes the
// source holds a beat steady until it is accepted, and that in_first
// marks the first beat of every frame.
module tx_pad_crc
    import tx_pad_crc_pkg::*;
#(
    parameter int MIN_PAYLOAD = 60,
    parameter int FCS_BYTES   = 4,
    localparam int CW = $clog2(MIN_PAYLOAD + 1),
    localparam int IW = $clog2(FCS_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_fcs_off,
    input  logic       in_pad_off,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);
    phase_t        phase_q;
    logic          fcs_off_q, pad_off_q;
    logic [IW-1:0] fcs_idx_q;
    logic [CW-1:0] cnt_next;
    logic [31:0]   fcs;
    logic          in_fire, out_fire, adv, rst_cnt;
    logic          eff_fcs_off, eff_pad_off, need_pad, add_fcs;
    logic [7:0]    crc_din;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Use the flags from the first beat, or the stored ones after it.
    always_comb begin
        eff_fcs_off = in_first ? in_fcs_off : fcs_off_q;
        eff_pad_off = in_first ? in_pad_off : pad_off_q;
        need_pad    = !eff_pad_off && (cnt_next < CW'(MIN_PAYLOAD));
        add_fcs     = need_pad || !eff_fcs_off;
    end

    // Feed the counter and CRC from payload beats and pad beats.
    always_comb begin
        adv     = (phase_q == PH_DATA && in_fire) || (phase_q == PH_PAD && out_fire);
        rst_cnt = (phase_q == PH_DATA) && in_first;
        crc_din = (phase_q == PH_PAD) ? 8'h00 : in_data;
    end

    txpc_len_ctr #(.LIMIT(MIN_PAYLOAD)) u_len (
        .clk(clk), .rst_n(rst_n), .restart(rst_cnt), .advance(adv),
        .cnt_next(cnt_next)
    );

    txpc_crc_reg #(.CRC_W(32)) u_crc (
        .clk(clk), .rst_n(rst_n), .restart(rst_cnt), .advance(adv),
        .din(crc_din), .fcs(fcs)
    );

    // Drive the output beat and input ready from the current phase.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        unique case (phase_q)
            PH_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last && !add_fcs;
            end
            PH_PAD: begin
                out_valid = 1'b1;
            end
            PH_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs[{fcs_idx_q, 3'b000} +: 8];
                out_last  = (fcs_idx_q == IW'(FCS_BYTES - 1));
            end
            default: ;
        endcase
    end

    // Store the frame flags that come with the first beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcs_off_q <= 1'b0;
            pad_off_q <= 1'b0;
        end else if (in_fire && in_first) begin
            fcs_off_q <= in_fcs_off;
            pad_off_q <= in_pad_off;
        end
    end

    // Step through data, pad and FCS phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_DATA;
            fcs_idx_q <= '0;
        end else begin
            unique case (phase_q)
                PH_DATA: if (in_fire && in_last) begin
                    fcs_idx_q <= '0;
                    if (need_pad)     phase_q <= PH_PAD;
                    else if (add_fcs) phase_q <= PH_FCS;
                end
                PH_PAD: if (out_fire && cnt_next == CW'(MIN_PAYLOAD)) begin
                    phase_q <= PH_FCS;
                end
                PH_FCS: if (out_fire) begin
                    fcs_idx_q <= fcs_idx_q + IW'(1);
                    if (out_last) phase_q <= PH_DATA;
                end
                default: phase_q <= PH_DATA;
            endcase
        end
    end
endmodule

// File: rtl/tx_pad_crc_chk.sv
// Protocol checker for tx_pad_crc, attached by bind. It watches the
// ports and the phase register and holds no state of its own.
module tx_pad_crc_chk
    import tx_pad_crc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic [1:0] phase
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready && out_data == in_data)); // R1
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAD && out_valid) |-> (out_data == 8'h00 && !out_last)); // R2
    AST_PAD_TO_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAD) |=> (phase == PH_PAD || phase == PH_FCS)); // R3
    AST_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DATA) |-> !in_ready); // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8
endmodule

bind tx_pad_crc tx_pad_crc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .phase(phase_q)
);

// File: tb/sim_tx_pad_crc.sv
module sim_tx_pad_crc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic       in_fcs_off = 1'b0, in_pad_off = 1'b0, out_ready = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_last;
    logic [7:0] out_data;
    int         checks = 0, errors = 0;

    always #5 clk = ~clk;

    tx_pad_crc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .in_fcs_off(in_fcs_off), .in_pad_off(in_pad_off),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    // Vector: {len[7:0], fcs_off, pad_off, noise, stall, 4'b0, exp_len[7:0]}
    localparam int NV = 11;
    localparam logic [23:0] VEC [NV] = '{
        {8'd10, 4'b0000, 4'h0, 8'd64},  // R2 R3 pad and FCS
        {8'd10, 4'b1000, 4'h0, 8'd64},  // R3 pad forces FCS
        {8'd10, 4'b0101, 4'h0, 8'd14},  // R4 no pad, FCS, stalled
        {8'd10, 4'b1100, 4'h0, 8'd10},  // R4 R9 no pad, no FCS
        {8'd60, 4'b0000, 4'h0, 8'd64},  // R4 exactly minimum
        {8'd59, 4'b1001, 4'h0, 8'd64},  // R2 one short, stalled
        {8'd60, 4'b1000, 4'h0, 8'd60},  // R4 no pad needed, no FCS
        {8'd1,  4'b0001, 4'h0, 8'd64},  // R2 single beat frame
        {8'd1,  4'b1100, 4'h0, 8'd1},   // R9 single beat, nothing added
        {8'd70, 4'b0011, 4'h0, 8'd74},  // R6 noisy flags later, stalled
        {8'd20, 4'b1110, 4'h0, 8'd20}   // R6 noisy flags later
    };

    logic [7:0] exp_b [128];
    logic [7:0] got_b [128];

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 3) & 255);
    endfunction

    function automatic logic [31:0] ref_crc(input int n, input int seed, input int padded);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < padded; i++) begin
            logic [7:0] b = (i < n) ? pay(i, seed) : 8'h00;
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ b[k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int v);
        int n = int'(VEC[v][23:16]);
        bit fo = VEC[v][15], po = VEC[v][14], noise = VEC[v][13], stall = VEC[v][12];
        int exp_len = int'(VEC[v][7:0]);
        bit pad = !po && n < 60;
        bit fcs = pad || !fo;
        int body = pad ? 60 : n;
        int sent = 0, extra = 0, rcv = 0, last_at = -1, cyc = 0, mism = 0;
        bit done = 0;
        logic [31:0] c = ref_crc(n, v, body);
        for (int i = 0; i < body; i++) exp_b[i] = (i < n) ? pay(i, v) : 8'h00;
        for (int i = 0; i < 4; i++) exp_b[body + i] = c[8*i +: 8];
        while (!done && cyc < 600) begin
            @(negedge clk);
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (sent < n) begin
                in_valid = 1'b1; in_data = pay(sent, v);
                in_first = (sent == 0); in_last = (sent == n - 1);
                in_fcs_off = (sent == 0 || !noise) ? fo : ~fo;
                in_pad_off = (sent == 0 || !noise) ? po : ~po;
            end else if (exp_len > n) begin
                in_valid = 1'b1; in_data = 8'hA5; in_first = 1'b1; in_last = 1'b1;
                in_fcs_off = 1'b1; in_pad_off = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (in_valid && in_ready) begin
                if (sent < n) sent++; else extra++;
            end
            if (out_valid && out_ready) begin
                if (rcv < 128) got_b[rcv] = out_data;
                if (out_last) begin last_at = rcv; done = 1; end
                rcv++;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        check(rcv == (fcs ? body + 4 : body) && rcv == exp_len,
              "R2 R3 R4 R6 frame length", rcv, exp_len);
        for (int i = 0; i < rcv && i < 128; i++) if (got_b[i] !== exp_b[i]) mism++;
        check(mism == 0, "R1 R2 R5 byte content mismatches", mism, 0);
        check(last_at == exp_len - 1, "R9 end marker position", last_at, exp_len - 1);
        check(sent == n && extra == 0, "R7 input beats taken", sent + extra, n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10 in_ready in reset", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check(in_ready == 1'b0 && out_valid == 1'b0, "R10 ready follows out_ready",
              int'(in_ready), 0);
        out_ready = 1'b1;
        for (int v = 0; v < NV; v++) run_frame(v);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule